// File: doc/BRIEF.md
# FIFO DMA request controller

This block generates the DMA request for a byte FIFO that drains towards the host, as in a parallel-port style transfer engine. It watches how many bytes the FIFO holds and the host's acknowledge, read strobe and terminal-count signals. From these it decides when to raise and when to drop the request line. It also limits how long an unbroken burst may run, and it raises a service interrupt when the host signals terminal count.

Software controls the block through two bits, a DMA enable and a service flag, written together with one strobe. The service flag is the usual way to pause or stop transfers. The hardware sets it by itself on terminal count, which parks the request until software clears the flag again.

The acknowledge, read-strobe and terminal-count inputs are asynchronous and pass through two-stage synchronisers. The FIFO level and the configuration write are synchronous to the block clock.

Top module: `dma_req_ctl`

## Requirements
- R1: With enable set and the service flag clear, `dreq` is 1 in the cycle after the FIFO level becomes non-zero. `dreq` is never 1 while enable is 0 or the service flag is 1.
- R2: `dreq` drops in the cycle after the level reaches 0. If the FIFO emptying was the only cause of the drop, `dreq` returns in the cycle after the level is again at least 1.
- R3: Terminal count counts only while acknowledge is active. When it is seen with enable set and the service flag clear, the block drops `dreq`, sets the service flag and drives `irq` high for exactly one cycle.
- R4: After a terminal-count drop, `dreq` stays 0 until software clears the service flag. In the cycle after that write, `dreq` is 1 again if the level is at least 1.
- R5: If a configuration write lands in the same cycle as a qualified terminal count, the hardware setting of the service flag wins over the written value.
- R6: With the request high and a level of exactly 1, an acknowledge turning active drops `dreq` three cycles after the input pin changes. The request stays low until the level has been 0.
- R7: With the request high, a level of exactly 1 and acknowledge held active, a read strobe turning active drops `dreq` in the same way.
- R8: After 32 completed acknowledge cycles in one burst, `dreq` is forced low. It stays low until acknowledge has been inactive for ceil(350 ns / clock period) consecutive cycles, which is 88 cycles at 4 ns. Then the burst count restarts from 0. Any other drop of `dreq` also resets the count.
- R9: `fifo_pop` pulses for exactly one cycle for each assertion of acknowledge, whatever the state of enable, the service flag or `dreq`.
- R10: Writing the service flag to 1 and then enable to 0 keeps `dreq` at 0 from then on, even while the FIFO holds data.
- R11: After reset, `dreq` and `irq` are 0, enable is 0 and the service flag is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| fifo_level | input | LVL_W | Bytes currently held in the FIFO |
| dack_n | input | 1 | DMA acknowledge from host, active low, asynchronous |
| iord_n | input | 1 | Host I/O read strobe, active low, asynchronous |
| tc | input | 1 | Terminal count from host DMA, active high, asynchronous |
| cfg_we | input | 1 | Write strobe for the two control bits |
| cfg_dma_en | input | 1 | Value written to the enable bit |
| cfg_svc | input | 1 | Value written to the service flag |
| dreq | output | 1 | DMA request to host |
| irq | output | 1 | One-cycle service interrupt pulse |
| dma_en | output | 1 | Current enable bit |
| svc_intr | output | 1 | Current service flag |
| fifo_pop | output | 1 | One-cycle FIFO read enable per acknowledge |

## Verification
Two updates to the service flag can fall in the same clock cycle: the hardware setting it on a qualified terminal count, and a software write that tries to clear it. The bench times terminal count against a held acknowledge so that the synchronised terminal count reaches the control logic in exactly the cycle in which the configuration strobe is high with the flag written to 0. It then requires the flag to read 1, the one-cycle interrupt to appear and the request to be low in the next cycle. In the cycle after that, the interrupt must be back to 0.

// File: rtl/dma_req_pkg.sv
`timescale 1ns/1ps
package dma_req_pkg;

    // Bit positions inside the synchroniser vector
    localparam int unsigned SIG_ACK  = 0;
    localparam int unsigned SIG_RD   = 1;
    localparam int unsigned SIG_TC   = 2;
    localparam int unsigned NUM_IN   = 3;
    // Only acknowledge and read strobe need edge history
    localparam int unsigned NUM_EDGE = 2;

    typedef struct packed {
        logic dreq;
        logic irq;
        logic dma_en;
        logic svc;
        logic last_hold;
    } ctl_state_t;

    localparam ctl_state_t CTL_RESET = '{
        dreq:      1'b0,
        irq:       1'b0,
        dma_en:    1'b0,
        svc:       1'b1,
        last_hold: 1'b0
    };

endpackage

// File: rtl/dma_req_sync.sv
`timescale 1ns/1ps
module dma_req_sync #(
    parameter int unsigned W      = 3,
    parameter int unsigned EDGE_W = 2,
    parameter int unsigned STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      raw,
    output logic [W-1:0]      lvl,
    output logic [EDGE_W-1:0] prv
);

    logic [W-1:0]      stage_q [STAGES];
    logic [EDGE_W-1:0] prv_q;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= raw;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[g] <= '0;
                else        stage_q[g] <= stage_q[g-1];
            end
        end
    end

    // One more register on the low bits gives the previous value for edges
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prv_q <= '0;
        else        prv_q <= stage_q[STAGES-1][EDGE_W-1:0];
    end

    assign lvl = stage_q[STAGES-1];
    assign prv = prv_q;

endmodule

// File: rtl/dma_req_burst.sv
`timescale 1ns/1ps
module dma_req_burst #(
    parameter  int unsigned MAX_BURST = 32,
    parameter  int unsigned GAP_CYC   = 88,
    localparam int unsigned CNT_W     = $clog2(MAX_BURST + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ack_act,
    input  logic             ack_fall,
    input  logic             clr,
    output logic             cap,
    output logic [CNT_W-1:0] cnt
);

    localparam int unsigned GAP_W = $clog2(GAP_CYC + 1);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(MAX_BURST - 1);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(GAP_CYC - 1);

    typedef struct packed {
        logic             cap;
        logic [CNT_W-1:0] cnt;
        logic [GAP_W-1:0] gap;
    } burst_t;

    burst_t st_d, st_q;
    logic   hit_last;

    assign hit_last = ack_fall && (st_q.cnt == CNT_LAST);

    always_comb begin
        st_d = st_q;
        if (st_q.cap) begin
            // Capped: wait for a continuous idle-acknowledge window
            if (ack_act) begin
                st_d.gap = '0;
            end else if (st_q.gap == GAP_LAST) begin
                st_d.cap = 1'b0;
                st_d.cnt = '0;
                st_d.gap = '0;
            end else begin
                st_d.gap = st_q.gap + 1'b1;
            end
        end else if (hit_last) begin
            st_d.cap = 1'b1;
            st_d.cnt = st_q.cnt + 1'b1;
            st_d.gap = '0;
        end else if (clr) begin
            st_d.cnt = '0;
        end else if (ack_fall) begin
            st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Cap takes effect in the same cycle as the final acknowledge completes
    assign cap = st_q.cap | hit_last;
    assign cnt = st_q.cnt;

endmodule

// File: rtl/dma_req_ctl.sv
`timescale 1ns/1ps
module dma_req_ctl
    import dma_req_pkg::*;
#(
    parameter  int unsigned LVL_W         = 5,
    parameter  int unsigned MAX_BURST     = 32,
    parameter  int unsigned CLK_PERIOD_PS = 4000,
    parameter  int unsigned GAP_PS        = 350000,
    localparam int unsigned GAP_CYC       = (GAP_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS,
    localparam int unsigned CNT_W         = $clog2(MAX_BURST + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LVL_W-1:0] fifo_level,
    input  logic             dack_n,
    input  logic             iord_n,
    input  logic             tc,
    input  logic             cfg_we,
    input  logic             cfg_dma_en,
    input  logic             cfg_svc,
    output logic             dreq,
    output logic             irq,
    output logic             dma_en,
    output logic             svc_intr,
    output logic             fifo_pop
);

    // Synchronised inputs, all active high
    logic [NUM_IN-1:0]   raw_in;
    logic [NUM_IN-1:0]   in_lvl;
    logic [NUM_EDGE-1:0] in_prv;

    assign raw_in = {tc, ~iord_n, ~dack_n};

    dma_req_sync #(
        .W      (NUM_IN),
        .EDGE_W (NUM_EDGE),
        .STAGES (2)
    ) sync_i (
        .clk   (clk),
        .rst_n (rst_n),
        .raw   (raw_in),
        .lvl   (in_lvl),
        .prv   (in_prv)
    );

    logic ack_act, ack_rise, ack_fall, rd_rise, tc_hit;

    assign ack_act  = in_lvl[SIG_ACK];
    assign ack_rise = in_lvl[SIG_ACK] & ~in_prv[SIG_ACK];
    assign ack_fall = ~in_lvl[SIG_ACK] & in_prv[SIG_ACK];
    assign rd_rise  = in_lvl[SIG_RD] & ~in_prv[SIG_RD];
    // Terminal count is qualified by an active acknowledge
    assign tc_hit   = in_lvl[SIG_TC] & ack_act;

    logic have_data, one_left;

    assign have_data = (fifo_level != '0);
    assign one_left  = (fifo_level == LVL_W'(1));

    // Burst limiter
    logic             burst_cap;
    logic             burst_clr;
    logic [CNT_W-1:0] burst_cnt;

    dma_req_burst #(
        .MAX_BURST (MAX_BURST),
        .GAP_CYC   (GAP_CYC)
    ) burst_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .ack_act  (ack_act),
        .ack_fall (ack_fall),
        .clr      (burst_clr),
        .cap      (burst_cap),
        .cnt      (burst_cnt)
    );

    // Control state
    ctl_state_t ctl_d, ctl_q;
    logic       armed_q;
    logic       tc_drop;

    assign armed_q = ctl_q.dma_en & ~ctl_q.svc;
    assign tc_drop = armed_q & tc_hit;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.irq = 1'b0;

        if (cfg_we) begin
            ctl_d.dma_en = cfg_dma_en;
            ctl_d.svc    = cfg_svc;
        end

        // Hardware setting of the flag is applied last so it wins
        if (tc_drop) begin
            ctl_d.svc = 1'b1;
            ctl_d.irq = 1'b1;
        end

        // Last-byte hold: set by the first active edge, cleared by empty
        if (!have_data) begin
            ctl_d.last_hold = 1'b0;
        end else if (ctl_q.dreq && one_left && (ack_rise || rd_rise)) begin
            ctl_d.last_hold = 1'b1;
        end

        ctl_d.dreq = ctl_d.dma_en & ~ctl_d.svc & have_data
                   & ~burst_cap & ~ctl_d.last_hold;
    end

    // A drop not caused by the cap restarts the burst count
    assign burst_clr = ctl_q.dreq & ~ctl_d.dreq & ~burst_cap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctl_q <= CTL_RESET;
        else        ctl_q <= ctl_d;
    end

    assign dreq     = ctl_q.dreq;
    assign irq      = ctl_q.irq;
    assign dma_en   = ctl_q.dma_en;
    assign svc_intr = ctl_q.svc;
    assign fifo_pop = ack_rise;

endmodule

// File: rtl/dma_req_ctl_chk.sv
`timescale 1ns/1ps
module dma_req_ctl_chk #(
    parameter int unsigned LVL_W     = 5,
    parameter int unsigned MAX_BURST = 32,
    parameter int unsigned CNT_W     = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dreq,
    input logic             irq,
    input logic             dma_en,
    input logic             svc_intr,
    input logic [LVL_W-1:0] fifo_level,
    input logic [CNT_W-1:0] burst_cnt
);

    assert_req_gated_R1: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> (dma_en && !svc_intr));

    assert_req_has_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
        dreq |-> $past(fifo_level != '0));

    assert_irq_with_flag_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ($rose(svc_intr) && !dreq));

    assert_irq_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq |=> !irq);

    assert_cap_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (burst_cnt == CNT_W'(MAX_BURST)) |-> !dreq);

    assert_cnt_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
        burst_cnt <= CNT_W'(MAX_BURST));

endmodule

bind dma_req_ctl dma_req_ctl_chk #(
    .LVL_W     (LVL_W),
    .MAX_BURST (MAX_BURST),
    .CNT_W     (CNT_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .dreq       (dreq),
    .irq        (irq),
    .dma_en     (dma_en),
    .svc_intr   (svc_intr),
    .fifo_level (fifo_level),
    .burst_cnt  (burst_cnt)
);

// File: tb/dma_req_ctl_tb_top.sv
`timescale 1ns/1ps
module dma_req_ctl_tb_top;

    localparam int unsigned LVL_W = 5;
    localparam int SEL_DREQ = 0;
    localparam int SEL_IRQ  = 1;
    localparam int SEL_SVC  = 2;
    localparam int SEL_EN   = 3;
    localparam int SEL_POP  = 4;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [LVL_W-1:0] fifo_level = '0;
    logic             dack_n = 1'b1;
    logic             iord_n = 1'b1;
    logic             tc = 1'b0;
    logic             cfg_we = 1'b0;
    logic             cfg_dma_en = 1'b0;
    logic             cfg_svc = 1'b0;
    logic             dreq, irq, dma_en, svc_intr, fifo_pop;

    int checks = 0;
    int errors = 0;
    int pop_cnt = 0;
    bit finished = 1'b0;

    dma_req_ctl dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .fifo_level (fifo_level),
        .dack_n     (dack_n),
        .iord_n     (iord_n),
        .tc         (tc),
        .cfg_we     (cfg_we),
        .cfg_dma_en (cfg_dma_en),
        .cfg_svc    (cfg_svc),
        .dreq       (dreq),
        .irq        (irq),
        .dma_en     (dma_en),
        .svc_intr   (svc_intr),
        .fifo_pop   (fifo_pop)
    );

    always #2ns clk = ~clk;

    always @(negedge clk) if (fifo_pop) pop_cnt++;

    // Scoreboard: expectations refer to the state after the next rising edge
    typedef struct {
        string tag;
        int    sel;
        int    exp;
    } sb_item_t;

    sb_item_t sb[$];

    function automatic int actual(int sel);
        case (sel)
            SEL_DREQ: return int'(dreq);
            SEL_IRQ:  return int'(irq);
            SEL_SVC:  return int'(svc_intr);
            SEL_EN:   return int'(dma_en);
            default:  return pop_cnt;
        endcase
    endfunction

    always @(posedge clk) begin
        #1ns;
        while (sb.size() > 0) begin
            sb_item_t it;
            int act;
            it  = sb.pop_front();
            act = actual(it.sel);
            checks++;
            if (act != it.exp) begin
                errors++;
                $display("FAIL %s: actual=%0d expected=%0d", it.tag, act, it.exp);
            end
        end
    end

    task automatic expect_v(input string tag, input int sel, input int exp);
        sb_item_t it;
        it.tag = tag;
        it.sel = sel;
        it.exp = exp;
        sb.push_back(it);
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic cfg_write(input logic en, input logic svc);
        cfg_we = 1'b1; cfg_dma_en = en; cfg_svc = svc;
        step(1);
        cfg_we = 1'b0;
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog (all requirements): actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        int base;
        step(3);
        rst_n = 1'b1;
        // R11 reset state
        expect_v("R11 dreq", SEL_DREQ, 0);
        expect_v("R11 irq", SEL_IRQ, 0);
        expect_v("R11 svc", SEL_SVC, 1);
        expect_v("R11 enable", SEL_EN, 0);
        step(2);

        // R1 enable with data present
        fifo_level = 5'd3;
        cfg_we = 1'b1; cfg_dma_en = 1'b1; cfg_svc = 1'b0;
        expect_v("R1 dreq", SEL_DREQ, 1);
        expect_v("R1 enable", SEL_EN, 1);
        step(1);
        cfg_we = 1'b0;

        // R2 empty drop and re-arm
        fifo_level = 5'd0;
        expect_v("R2 drop on empty", SEL_DREQ, 0);
        step(1);
        fifo_level = 5'd1;
        expect_v("R2 re-arm on one byte", SEL_DREQ, 1);
        step(1);

        // R6 last byte, acknowledge edge
        dack_n = 1'b0;
        step(2);
        expect_v("R6 drop on ack edge", SEL_DREQ, 0);
        step(2);
        dack_n = 1'b1;
        step(6);
        expect_v("R6 held low at level 1", SEL_DREQ, 0);
        step(1);
        fifo_level = 5'd0;
        step(2);
        fifo_level = 5'd2;
        expect_v("R6 returns after empty", SEL_DREQ, 1);
        step(1);

        // R7 last byte, read strobe with acknowledge held
        dack_n = 1'b0;
        step(4);
        fifo_level = 5'd1;
        step(2);
        expect_v("R7 still high before strobe", SEL_DREQ, 1);
        iord_n = 1'b0;
        step(2);
        expect_v("R7 drop on read strobe", SEL_DREQ, 0);
        step(1);
        iord_n = 1'b1;
        dack_n = 1'b1;
        step(4);
        fifo_level = 5'd0;
        step(2);

        // R3 / R5 terminal count racing a software clear
        fifo_level = 5'd4;
        expect_v("R3 request up before tc", SEL_DREQ, 1);
        step(1);
        dack_n = 1'b0;
        step(4);
        tc = 1'b1;
        step(2);
        cfg_we = 1'b1; cfg_dma_en = 1'b1; cfg_svc = 1'b0;
        expect_v("R3 drop on tc", SEL_DREQ, 0);
        expect_v("R3 irq pulse", SEL_IRQ, 1);
        expect_v("R5 flag set wins over write", SEL_SVC, 1);
        step(1);
        cfg_we = 1'b0;
        expect_v("R3 irq one cycle", SEL_IRQ, 0);
        tc = 1'b0;
        dack_n = 1'b1;
        step(6);

        // R4 parked until software clears the flag
        expect_v("R4 parked with data", SEL_DREQ, 0);
        step(1);
        cfg_we = 1'b1; cfg_dma_en = 1'b1; cfg_svc = 1'b0;
        expect_v("R4 flag cleared", SEL_SVC, 0);
        expect_v("R4 re-armed", SEL_DREQ, 1);
        step(1);
        cfg_we = 1'b0;

        // R8 burst cap: fresh count via an empty drop
        fifo_level = 5'd0;
        step(2);
        fifo_level = 5'd20;
        step(2);
        base = pop_cnt;
        for (int i = 0; i < 31; i++) begin
            dack_n = 1'b0; step(3);
            dack_n = 1'b1; step(3);
        end
        expect_v("R8 high after 31 cycles", SEL_DREQ, 1);
        step(1);
        dack_n = 1'b0; step(3);
        dack_n = 1'b1; step(4);
        expect_v("R8 low after 32 cycles", SEL_DREQ, 0);
        expect_v("R9 one pop per acknowledge", SEL_POP, base + 32);
        step(60);
        expect_v("R8 low inside idle gap", SEL_DREQ, 0);
        step(50);
        expect_v("R8 returns after idle gap", SEL_DREQ, 1);
        step(1);

        // R10 orderly stop
        cfg_write(1'b1, 1'b1);
        cfg_write(1'b0, 1'b1);
        fifo_level = 5'd5;
        step(10);
        expect_v("R10 low after stop", SEL_DREQ, 0);
        expect_v("R10 enable cleared", SEL_EN, 0);
        step(1);

        // R9 pops while disabled
        base = pop_cnt;
        for (int i = 0; i < 3; i++) begin
            dack_n = 1'b0; step(3);
            dack_n = 1'b1; step(3);
        end
        step(2);
        expect_v("R9 pops while disabled", SEL_POP, base + 3);
        expect_v("R10 still low during acks", SEL_DREQ, 0);
        step(3);

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule